// File: doc/BRIEF.md
# Switchable-Width Accumulator ALU Slice

This block is the accumulator and arithmetic slice of a small processor datapath. It holds one accumulator register. The register works either as a full 16-bit word or as an 8-bit register. In 8-bit use, the upper byte sits untouched and serves as scratch storage. The slice runs add with carry, subtract with borrow, AND, OR, exclusive-OR and a pass-through load on the active width. It keeps carry, negative, overflow and zero flags that follow those results.

Two inputs choose the width. A compatibility-mode input forces 8-bit operation whenever it is high. When that input is low, a width-select bit picks 8 bits (1) or 16 bits (0). A dedicated exchange operation swaps the two bytes of the accumulator. This lets the hidden upper byte be brought into the low byte, and moved back out, at any width. The surrounding control logic presents an operation code, an operand and a write-enable each cycle. It reads the accumulator and the flags back from the outputs.

Top module: `acc_alu_slice`

## Requirements
- R1: With emu_mode=0 and m_sel=0, every operation acts on all 16 bits. N is bit 15 of the result, Z is set when all 16 bits are zero, C is the carry out of bit 15, and V is two's-complement overflow of the 16-bit result.
- R2: When m_sel=1 or emu_mode=1, the slice is 8 bits wide and emu_mode=1 overrides m_sel=0. Operations use only bits 7:0. N is bit 7, Z tests the low byte, C is the carry out of bit 7, and V is 8-bit signed overflow.
- R3: In 8-bit width, no operation other than exchange changes bits 15:8 of the accumulator.
- R4: op_code 6 (exchange) swaps bits 15:8 with bits 7:0 at either width. It sets N from bit 7 and Z from the new low byte, and leaves C and V unchanged.
- R5: The op_code values are 0 load operand, 1 add with carry (acc + operand + C), 2 subtract with borrow (acc + ~operand + C, so C=1 means no borrow), 3 AND, 4 OR, 5 exclusive-OR, and 7 no operation. No operation changes neither the accumulator nor any flag.
- R6: Load, AND, OR and exclusive-OR update N and Z only. C and V keep their values.
- R7: While wr_en=0, the accumulator and all four flags hold whatever the other inputs are.
- R8: A rising clock edge with rst_n=0 clears the accumulator and all four flags, whatever wr_en is.
- R9: A result and its flags appear on the outputs right after the rising edge at which wr_en=1 was sampled. There is one register stage and no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Commit the operation at this edge |
| op_code | input | 3 | Operation select (see R5) |
| operand | input | 16 | Second operand |
| emu_mode | input | 1 | Compatibility mode; forces 8-bit width |
| m_sel | input | 1 | Width select when emu_mode=0: 1 = 8-bit, 0 = 16-bit |
| acc_out | output | 16 | Accumulator contents |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
Every result of this slice, whether accumulator, carry, negative, overflow or zero, is due exactly one rising edge after the inputs that cause it are sampled. Reset clearing is due at that same single edge. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge. It then compares the accumulator and the flag vector at the following falling edge, so each comparison sees the state just one register stage later. Hold cases, such as write-enable low, the no-operation code and the preserved high byte, are compared in the very next cycle, before any further stimulus could change them.

// File: rtl/acc_alu_pkg.sv
// Shared types for the switchable-width accumulator slice.
// Assumes a 3-bit operation code; the code values are fixed by the interface.
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_ADC  = 3'd1,
        OP_SBC  = 3'd2,
        OP_AND  = 3'd3,
        OP_ORA  = 3'd4,
        OP_EOR  = 3'd5,
        OP_XCHG = 3'd6,
        OP_NOP  = 3'd7
    } acc_op_e;

    typedef struct packed {
        logic c;
        logic n;
        logic v;
        logic z;
    } acc_flags_t;

endpackage

// File: rtl/acc_lane_ctl.sv
// Width control: decides whether the slice works on the low half only and
// builds the mask of active result bits used for zero detection.
// Assumes DATA_W is even; the narrow lane is the low DATA_W/2 bits.
module acc_lane_ctl #(
    parameter int DATA_W = 16
) (
    input  logic              emu_mode,
    input  logic              m_sel,
    output logic              narrow,
    output logic [DATA_W-1:0] lane_mask
);
    localparam int HALF_W = DATA_W / 2;

    // Compatibility mode forces narrow width regardless of the select bit.
    always_comb narrow = emu_mode | m_sel;

    // One mask bit per data bit: the upper half is active only in wide mode.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i < HALF_W) begin : g_low
            assign lane_mask[i] = 1'b1;
        end else begin : g_high
            assign lane_mask[i] = ~narrow;
        end
    end
endmodule

// File: rtl/acc_adder.sv
// Parameterised ripple-free adder with carry in, carry out and signed
// overflow. Used once per lane width.
// Assumes operands are already inverted by the caller for subtraction.
module acc_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] full;

    // Sum with an extra bit to capture the carry out.
    always_comb full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

    // Split the result and derive two's-complement overflow.
    always_comb begin
        sum  = full[W-1:0];
        cout = full[W];
        ovf  = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/acc_alu_core.sv
// Combinational datapath: computes the next accumulator value, the next
// flag values and which of them are to be written for the current op.
// Assumes the state register applies the update enables only when wr_en=1.
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] acc_q,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    input  logic [2:0]        op_code,
    input  logic              narrow,
    input  logic [DATA_W-1:0] lane_mask,
    output logic [DATA_W-1:0] acc_d,
    output acc_flags_t        flags_d,
    output logic              upd_acc,
    output logic              upd_nz,
    output logic              upd_cv
);
    localparam int HALF_W = DATA_W / 2;

    acc_op_e           op;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] sum_w;
    logic [HALF_W-1:0] sum_h;
    logic              c_w, v_w, c_h, v_h;
    logic [DATA_W-1:0] logic_res;
    logic              is_arith;
    logic [DATA_W-1:0] wide_res;
    logic [HALF_W-1:0] narrow_res;
    logic [DATA_W-1:0] lane_val;

    // Decode the raw code into the enumerated operation.
    always_comb op = acc_op_e'(op_code);

    // Subtraction is addition of the complemented operand.
    always_comb b_eff = (op == OP_SBC) ? ~operand : operand;

    // Full-width adder for 16-bit operation.
    acc_adder #(.W(DATA_W)) u_add_wide (
        .a    (acc_q),
        .b    (b_eff),
        .cin  (carry_in),
        .sum  (sum_w),
        .cout (c_w),
        .ovf  (v_w)
    );

    // Half-width adder for 8-bit operation; carry and overflow at bit 7.
    acc_adder #(.W(HALF_W)) u_add_narrow (
        .a    (acc_q[HALF_W-1:0]),
        .b    (b_eff[HALF_W-1:0]),
        .cin  (carry_in),
        .sum  (sum_h),
        .cout (c_h),
        .ovf  (v_h)
    );

    // Bitwise operations and load share one selector.
    always_comb begin
        unique case (op)
            OP_AND:  logic_res = acc_q & operand;
            OP_ORA:  logic_res = acc_q | operand;
            OP_EOR:  logic_res = acc_q ^ operand;
            default: logic_res = operand;
        endcase
    end

    // Pick between arithmetic and logic results for each lane width.
    always_comb begin
        is_arith   = (op == OP_ADC) || (op == OP_SBC);
        wide_res   = is_arith ? sum_w : logic_res;
        narrow_res = is_arith ? sum_h : logic_res[HALF_W-1:0];
    end

    // Next accumulator: exchange swaps halves, narrow keeps the upper half.
    always_comb begin
        if (op == OP_XCHG) begin
            acc_d = {acc_q[HALF_W-1:0], acc_q[DATA_W-1:HALF_W]};
        end else if (narrow) begin
            acc_d = {acc_q[DATA_W-1:HALF_W], narrow_res};
        end else begin
            acc_d = wide_res;
        end
    end

    // Value whose active bits feed the zero test.
    always_comb lane_val = narrow ? {{HALF_W{1'b0}}, narrow_res} : wide_res;

    // Next flags for the active width; exchange always uses the new low half.
    always_comb begin
        if (op == OP_XCHG) begin
            flags_d.n = acc_q[DATA_W-1];
            flags_d.z = (acc_q[DATA_W-1:HALF_W] == '0);
            flags_d.c = 1'b0;
            flags_d.v = 1'b0;
        end else if (narrow) begin
            flags_d.n = narrow_res[HALF_W-1];
            flags_d.z = ((lane_val & lane_mask) == '0);
            flags_d.c = c_h;
            flags_d.v = v_h;
        end else begin
            flags_d.n = wide_res[DATA_W-1];
            flags_d.z = ((lane_val & lane_mask) == '0);
            flags_d.c = c_w;
            flags_d.v = v_w;
        end
    end

    // Which parts of the state this operation is allowed to change.
    always_comb begin
        upd_acc = (op != OP_NOP);
        upd_nz  = (op != OP_NOP);
        upd_cv  = is_arith;
    end
endmodule

// File: rtl/acc_state_reg.sv
// Accumulator and flag storage with synchronous active-low reset.
// Assumes the update enables are only meaningful while wr_en is high.
module acc_state_reg
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              upd_acc,
    input  logic              upd_nz,
    input  logic              upd_cv,
    input  logic [DATA_W-1:0] acc_d,
    input  acc_flags_t        flags_d,
    output logic [DATA_W-1:0] acc_q,
    output acc_flags_t        flags_q
);
    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (wr_en && upd_acc) begin
            acc_q <= acc_d;
        end
    end

    // Negative and zero flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.n <= 1'b0;
            flags_q.z <= 1'b0;
        end else if (wr_en && upd_nz) begin
            flags_q.n <= flags_d.n;
            flags_q.z <= flags_d.z;
        end
    end

    // Carry and overflow flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.c <= 1'b0;
            flags_q.v <= 1'b0;
        end else if (wr_en && upd_cv) begin
            flags_q.c <= flags_d.c;
            flags_q.v <= flags_d.v;
        end
    end
endmodule

// File: rtl/acc_alu_slice.sv
// Top of the switchable-width accumulator slice: width control, datapath
// and state register. One register stage from inputs to outputs.
// Assumes DATA_W is even and at least 4.
module acc_alu_slice
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] operand,
    input  logic              emu_mode,
    input  logic              m_sel,
    output logic [DATA_W-1:0] acc_out,
    output logic              flag_c,
    output logic              flag_n,
    output logic              flag_v,
    output logic              flag_z
);
    logic              narrow;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] acc_d;
    acc_flags_t        flags_q;
    acc_flags_t        flags_d;
    logic              upd_acc, upd_nz, upd_cv;

    acc_lane_ctl #(.DATA_W(DATA_W)) u_lane (
        .emu_mode  (emu_mode),
        .m_sel     (m_sel),
        .narrow    (narrow),
        .lane_mask (lane_mask)
    );

    acc_alu_core #(.DATA_W(DATA_W)) u_core (
        .acc_q     (acc_q),
        .operand   (operand),
        .carry_in  (flags_q.c),
        .op_code   (op_code),
        .narrow    (narrow),
        .lane_mask (lane_mask),
        .acc_d     (acc_d),
        .flags_d   (flags_d),
        .upd_acc   (upd_acc),
        .upd_nz    (upd_nz),
        .upd_cv    (upd_cv)
    );

    acc_state_reg #(.DATA_W(DATA_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .upd_acc (upd_acc),
        .upd_nz  (upd_nz),
        .upd_cv  (upd_cv),
        .acc_d   (acc_d),
        .flags_d (flags_d),
        .acc_q   (acc_q),
        .flags_q (flags_q)
    );

    // Drive the outputs straight from the registers.
    always_comb begin
        acc_out = acc_q;
        flag_c  = flags_q.c;
        flag_n  = flags_q.n;
        flag_v  = flags_q.v;
        flag_z  = flags_q.z;
    end
endmodule

// File: rtl/acc_alu_slice_chk.sv
// Property checker for the accumulator slice, bound to every instance.
// Assumes the op_code values listed in the requirements.
module acc_alu_slice_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        op_code,
    input logic [DATA_W-1:0] operand,
    input logic              emu_mode,
    input logic              m_sel,
    input logic [DATA_W-1:0] acc_out,
    input logic              flag_c,
    input logic              flag_n,
    input logic              flag_v,
    input logic              flag_z
);
    localparam int HALF_W = DATA_W / 2;

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (acc_out == '0) && !flag_c && !flag_n && !flag_v && !flag_z); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(acc_out) && $stable(flag_c) && $stable(flag_n) && $stable(flag_v) && $stable(flag_z)); // R7

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && op_code == 3'd7) |=> $stable(acc_out) && $stable(flag_c) && $stable(flag_n) && $stable(flag_v) && $stable(flag_z)); // R5

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && (emu_mode || m_sel) && op_code != 3'd6) |=> acc_out[DATA_W-1:HALF_W] == $past(acc_out[DATA_W-1:HALF_W])); // R3

    AST_XCHG_SWAP: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && op_code == 3'd6) |=> acc_out == {$past(acc_out[HALF_W-1:0]), $past(acc_out[DATA_W-1:HALF_W])}); // R4

    AST_XCHG_NZ: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && op_code == 3'd6) |=> (flag_n == acc_out[HALF_W-1]) && (flag_z == (acc_out[HALF_W-1:0] == '0))); // R4

    AST_LOGIC_CV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && (op_code == 3'd0 || op_code == 3'd3 || op_code == 3'd4 || op_code == 3'd5 || op_code == 3'd6)) |=> $stable(flag_c) && $stable(flag_v)); // R6

    AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && op_code == 3'd0 && !emu_mode && !m_sel) |=> acc_out == $past(operand)); // R1

endmodule

bind acc_alu_slice acc_alu_slice_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .op_code  (op_code),
    .operand  (operand),
    .emu_mode (emu_mode),
    .m_sel    (m_sel),
    .acc_out  (acc_out),
    .flag_c   (flag_c),
    .flag_n   (flag_n),
    .flag_v   (flag_v),
    .flag_z   (flag_z)
);

// File: tb/acc_alu_slice_test.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural integer model advanced at each rising
// edge, compared with the outputs at the following falling edge.
module acc_alu_slice_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  op_code = 3'd7;
    logic [15:0] operand = 16'h0;
    logic        emu_mode = 1'b0;
    logic        m_sel = 1'b0;
    logic [15:0] acc_out;
    logic        flag_c, flag_n, flag_v, flag_z;

    int errors = 0;
    int checks = 0;
    int m_acc = 0;
    int mc = 0, mn = 0, mv = 0, mz = 0;

    always #10 clk = ~clk;

    acc_alu_slice uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .op_code  (op_code),
        .operand  (operand),
        .emu_mode (emu_mode),
        .m_sel    (m_sel),
        .acc_out  (acc_out),
        .flag_c   (flag_c),
        .flag_n   (flag_n),
        .flag_v   (flag_v),
        .flag_z   (flag_z)
    );

    // Reference: what the state should be after one edge with these inputs.
    task automatic model_step();
        int w, mask, a, b, s, r, hi;
        if (!rst_n) begin
            m_acc = 0; mc = 0; mn = 0; mv = 0; mz = 0;
            return;
        end
        if (!wr_en || op_code == 3'd7) return;
        if (op_code == 3'd6) begin
            hi = (m_acc >> 8) & 'hFF;
            m_acc = ((m_acc & 'hFF) << 8) | hi;
            mn = (hi >> 7) & 1;
            mz = (hi == 0) ? 1 : 0;
            return;
        end
        w = (emu_mode || m_sel) ? 8 : 16;
        mask = (1 << w) - 1;
        a = m_acc & mask;
        b = int'(operand) & mask;
        case (op_code)
            3'd1, 3'd2: begin
                if (op_code == 3'd2) b = (~b) & mask;
                s = a + b + mc;
                r = s & mask;
                mc = (s >> w) & 1;
                mv = ((((a ^ r) & (b ^ r)) >> (w - 1)) & 1);
            end
            3'd3: r = a & b;
            3'd4: r = a | b;
            3'd5: r = a ^ b;
            default: r = b;
        endcase
        mn = (r >> (w - 1)) & 1;
        mz = (r == 0) ? 1 : 0;
        m_acc = (w == 8) ? ((m_acc & 'hFF00) | r) : r;
    endtask

    // Drive one cycle of stimulus, then compare one edge later.
    task automatic cycle(input logic rst, input logic we, input logic [2:0] op,
                         input logic [15:0] d, input logic emu, input logic m,
                         input string tag);
        logic [3:0] exp_f, got_f;
        rst_n = rst; wr_en = we; op_code = op; operand = d;
        emu_mode = emu; m_sel = m;
        @(posedge clk);
        model_step();
        @(negedge clk);
        checks++;
        if (acc_out !== 16'(m_acc)) begin
            errors++;
            $display("FAIL %s acc: got %h expected %h", tag, acc_out, 16'(m_acc));
        end
        exp_f = {1'(mc), 1'(mn), 1'(mv), 1'(mz)};
        got_f = {flag_c, flag_n, flag_v, flag_z};
        checks++;
        if (got_f !== exp_f) begin
            errors++;
            $display("FAIL %s flags cnvz: got %b expected %b", tag, got_f, exp_f);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        cycle(0, 0, 3'd7, 16'h0000, 0, 0, "R8 reset");
        cycle(0, 1, 3'd0, 16'hFFFF, 0, 0, "R8 reset beats write");
        cycle(1, 1, 3'd0, 16'h1234, 0, 0, "R9 wide load");
        cycle(1, 1, 3'd1, 16'h0001, 0, 0, "R1 wide add");
        cycle(1, 1, 3'd0, 16'h7FFF, 0, 0, "R1 load");
        cycle(1, 1, 3'd1, 16'h0001, 0, 0, "R1 signed overflow");
        cycle(1, 1, 3'd0, 16'hFFFF, 0, 0, "R1 load");
        cycle(1, 1, 3'd1, 16'h0001, 0, 0, "R1 carry out zero");
        cycle(1, 1, 3'd2, 16'h0001, 0, 0, "R5 subtract no borrow");
        cycle(1, 1, 3'd2, 16'h0001, 0, 0, "R5 subtract with borrow");
        cycle(1, 1, 3'd0, 16'hAB12, 0, 0, "R1 load");
        cycle(1, 1, 3'd1, 16'h77F0, 0, 1, "R3 narrow add keeps upper");
        cycle(1, 1, 3'd2, 16'h0005, 0, 1, "R2 narrow subtract");
        cycle(1, 1, 3'd0, 16'h5580, 1, 0, "R2 emulation forces narrow");
        cycle(1, 1, 3'd1, 16'h0080, 1, 0, "R2 narrow overflow");
        cycle(1, 1, 3'd6, 16'h0000, 0, 1, "R4 exchange narrow");
        cycle(1, 1, 3'd6, 16'h0000, 0, 0, "R4 exchange wide");
        cycle(1, 1, 3'd0, 16'h0000, 0, 1, "R6 narrow load zero");
        cycle(1, 1, 3'd6, 16'h0000, 0, 0, "R4 exchange to zero low");
        cycle(1, 1, 3'd0, 16'hF0F0, 0, 0, "R6 load");
        cycle(1, 1, 3'd3, 16'h0FF0, 0, 0, "R6 and");
        cycle(1, 1, 3'd4, 16'h8001, 0, 0, "R6 or");
        cycle(1, 1, 3'd5, 16'h80F1, 0, 0, "R6 xor");
        cycle(1, 1, 3'd3, 16'h00FF, 0, 1, "R3 narrow and");
        cycle(1, 0, 3'd1, 16'h1111, 0, 0, "R7 write disabled");
        cycle(1, 0, 3'd6, 16'h0000, 0, 0, "R7 exchange disabled");
        cycle(1, 1, 3'd7, 16'hFFFF, 0, 0, "R5 no operation");
        cycle(1, 1, 3'd0, 16'h8000, 0, 0, "R1 negative load");
        cycle(0, 1, 3'd1, 16'h1234, 0, 0, "R8 mid-run reset");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule